// File: doc/BRIEF.md
# LPI Table Base Registers with Attribute Sanitising

This block holds the two 64-bit base registers that tell an interrupt redistributor where its LPI property table and its LPI pending table live in memory. It also holds the one-bit LPI-enable control that locks those registers. Software reaches them through a simple request port. Each request is either a 32-bit access to one half of a register or a 64-bit access to the whole register. Addresses on the port count 32-bit words: word bit 0 picks the half, and the remaining bits pick a register slot.

Every accepted base write is handled in two steps. First it is merged into the current value, replacing only the addressed half or the whole register. The merged value is then sanitised before it is stored:

- the shareability field at bits 11:10 turns code 2 (outer) into code 1 (inner);
- the inner-cacheability field at bits 9:7 turns codes 0 and 1 into code 7;
- the outer-cacheability field at bits 58:56 keeps codes 0 and 1 and turns every other code into 1;
- each table's reserved bits are cleared.

Reads always return the stored, sanitised value.

The enable control is a two-state machine. Its states are ST_LPI_OFF and ST_LPI_ON. Transition T_ARM goes from ST_LPI_OFF to ST_LPI_ON. It fires on a control write with bit 0 = 1, accepted only while `its_present` is high, and it produces a one-cycle `enable_pulse`. Transition T_DISARM goes from ST_LPI_ON to ST_LPI_OFF. It fires on a control write with bit 0 = 0, also gated by `its_present`, and it produces a one-cycle `flush_pulse`. Any other case holds the state (T_HOLD) and produces no pulse. While the state is ST_LPI_ON, both base registers ignore writes.

Top module: `lpi_table_regs`

## Requirements
- R1: After reset, both base registers and `lpi_en` read 0, and `flush_pulse`, `enable_pulse` and `rsp_valid` are 0.
- R2: A 32-bit write (`req_wide`=0) replaces only the half picked by `req_addr[0]` (0 = bits 31:0, 1 = bits 63:32) before sanitising. A 32-bit read returns that half in `rsp_rdata[31:0]`, with bits 63:32 zero.
- R3: A 64-bit access (`req_wide`=1) writes or reads the whole register, whatever the value of `req_addr[0]`.
- R4: In the stored value, shareability (bits 11:10) code 2 becomes 1, and codes 0, 1 and 3 are kept.
- R5: In the stored value, inner cacheability (bits 9:7) codes 0 and 1 become 7, and codes 2 to 7 are kept.
- R6: In the stored value, outer cacheability (bits 58:56) codes 0 and 1 are kept, and codes 2 to 7 become 1.
- R7: The property-table register (word addresses 4 and 5) always holds 0 in bits 63:59, 55:52 and 6:5 once it has been written.
- R8: The pending-table register (word addresses 6 and 7) always holds 0 in bits 63, 61:59, 55:52, 15:12 and 6:0 once it has been written.
- R9: While `lpi_en` is 1, writes to either base register are ignored.
- R10: The control register is at word address 0, and its bit 0 is `lpi_en`. A write there changes `lpi_en` only when `its_present` is 1. A 32-bit write to word 1 has no effect, and word 1 reads 0.
- R11: A write that takes `lpi_en` from 0 to 1 raises `enable_pulse`, and one that takes it from 1 to 0 raises `flush_pulse`. Each pulse lasts one cycle and comes in the same cycle that `lpi_en` changes. A write that leaves `lpi_en` unchanged produces no pulse.
- R12: A read request gives `rsp_valid`=1 with its data in the next cycle, and a write gives no response. Unmapped word addresses read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| its_present | input | 1 | Gates every change of the LPI-enable bit |
| req_valid | input | 1 | Request strobe, one access per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| req_addr | input | ADDR_W | 32-bit word address |
| req_wdata | input | 64 | Write data (a 32-bit write uses bits 31:0) |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 64 | Read data |
| lpi_en | output | 1 | Current LPI-enable state |
| flush_pulse | output | 1 | One-cycle pulse on disable |
| enable_pulse | output | 1 | One-cycle pulse on enable |

## Verification
The lock and the merge-and-sanitise path can meet in the same cycle. A base write issued in the very cycle that `flush_pulse` is high must already be accepted, and one issued in the cycle that `enable_pulse` is high must already be refused. The bench provokes both edges directly: it writes a base register in the cycle right after each control write, then reads the register back and compares it with its own model. The random phase mixes control writes, with `its_present` sometimes low, into random half-word and full-word traffic, so lock changes land next to partial merges of arbitrary field codes.

// File: rtl/lpi_tbl_pkg.sv
package lpi_tbl_pkg;

    localparam int WORD_W = 64;
    localparam int HALF_W = 32;

    typedef logic [WORD_W-1:0] word_t;

    // field placement
    localparam int SH_LSB  = 10;
    localparam int SH_W    = 2;
    localparam int IN_LSB  = 7;
    localparam int IN_W    = 3;
    localparam int OUT_LSB = 56;
    localparam int OUT_W   = 3;

    // attribute codes
    localparam logic [SH_W-1:0]  SH_OUTER  = 2'd2;
    localparam logic [SH_W-1:0]  SH_INNER  = 2'd1;
    localparam logic [IN_W-1:0]  IC_DEVICE = 3'd0;
    localparam logic [IN_W-1:0]  IC_NOCACHE = 3'd1;
    localparam logic [IN_W-1:0]  IC_RAWB   = 3'd7;
    localparam logic [OUT_W-1:0] OC_SAME   = 3'd0;
    localparam logic [OUT_W-1:0] OC_NOCACHE = 3'd1;

    // reserved masks
    localparam word_t PROP_RES0 = 64'hF8F0_0000_0000_0060;
    localparam word_t PEND_RES0 = 64'hB8F0_0000_0000_F07F;

    // register slots (word address >> 1)
    localparam int CTRL_SLOT = 0;
    localparam int TBL_SLOT0 = 2;
    localparam int NUM_TBL   = 2;

    typedef enum logic {
        ST_LPI_OFF = 1'b0,
        ST_LPI_ON  = 1'b1
    } lpi_state_e;

    typedef enum logic [1:0] {
        T_HOLD   = 2'd0,
        T_ARM    = 2'd1,
        T_DISARM = 2'd2
    } lpi_trans_e;

    function automatic word_t merge_half(input word_t cur, input word_t wd,
                                         input logic wide, input logic hi);
        word_t r;
        if (wide)
            r = wd;
        else if (hi)
            r = {wd[HALF_W-1:0], cur[HALF_W-1:0]};
        else
            r = {cur[WORD_W-1:HALF_W], wd[HALF_W-1:0]};
        return r;
    endfunction

    function automatic logic [SH_W-1:0] fix_share(input logic [SH_W-1:0] c);
        return (c == SH_OUTER) ? SH_INNER : c;
    endfunction

    function automatic logic [IN_W-1:0] fix_inner(input logic [IN_W-1:0] c);
        logic [IN_W-1:0] r;
        unique case (c)
            IC_DEVICE, IC_NOCACHE: r = IC_RAWB;
            default:               r = c;
        endcase
        return r;
    endfunction

    function automatic logic [OUT_W-1:0] fix_outer(input logic [OUT_W-1:0] c);
        logic [OUT_W-1:0] r;
        unique case (c)
            OC_SAME, OC_NOCACHE: r = c;
            default:             r = OC_NOCACHE;
        endcase
        return r;
    endfunction

    function automatic word_t sanitise(input word_t v, input word_t res0);
        word_t r;
        r = v;
        r[SH_LSB  +: SH_W]  = fix_share(v[SH_LSB  +: SH_W]);
        r[IN_LSB  +: IN_W]  = fix_inner(v[IN_LSB  +: IN_W]);
        r[OUT_LSB +: OUT_W] = fix_outer(v[OUT_LSB +: OUT_W]);
        return r & ~res0;
    endfunction

endpackage

// File: rtl/lpi_ctrl_fsm.sv
module lpi_ctrl_fsm
    import lpi_tbl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic its_present_i,
    input  logic wr_i,
    input  logic wr_bit_i,
    output logic en_o,
    output logic flush_o,
    output logic enable_o
);

    lpi_state_e state_q, state_d;
    lpi_trans_e trans;

    always_comb begin
        state_d = state_q;
        trans   = T_HOLD;
        unique case (state_q)
            ST_LPI_OFF: begin
                if (wr_i && its_present_i && wr_bit_i) begin
                    state_d = ST_LPI_ON;
                    trans   = T_ARM;
                end
            end
            ST_LPI_ON: begin
                if (wr_i && its_present_i && !wr_bit_i) begin
                    state_d = ST_LPI_OFF;
                    trans   = T_DISARM;
                end
            end
            default: begin
                state_d = ST_LPI_OFF;
                trans   = T_HOLD;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_LPI_OFF;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o     <= 1'b0;
            flush_o  <= 1'b0;
            enable_o <= 1'b0;
        end else begin
            en_o     <= (state_d == ST_LPI_ON);
            enable_o <= (trans == T_ARM);
            flush_o  <= (trans == T_DISARM);
        end
    end

    // R10: no ITS, no change
    a_r10_no_its_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !its_present_i |=> $stable(en_o));

    // R11: pulses mark real edges of the enable and never overlap
    a_r11_enable_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        enable_o |-> $rose(en_o));
    a_r11_flush_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> $fell(en_o));
    a_r11_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(flush_o && enable_o));
    a_r11_state_matches_out: assert property (@(posedge clk) disable iff (!rst_n)
        en_o == (state_q == ST_LPI_ON));

endmodule

// File: rtl/lpi_base_reg.sv
module lpi_base_reg
    import lpi_tbl_pkg::*;
#(
    parameter word_t RES0 = PROP_RES0
)(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_i,
    input  logic  wide_i,
    input  logic  hi_i,
    input  word_t wdata_i,
    input  logic  lock_i,
    output word_t q_o
);

    word_t merged;
    word_t cleaned;

    always_comb begin
        merged  = merge_half(q_o, wdata_i, wide_i, hi_i);
        cleaned = sanitise(merged, RES0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            q_o <= '0;
        else if (wr_i && !lock_i)
            q_o <= cleaned;
    end

    // R9: locked register holds
    a_r9_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        lock_i |=> $stable(q_o));

    // R4: outer shareability never stored
    a_r4_share_legal: assert property (@(posedge clk) disable iff (!rst_n)
        q_o[SH_LSB +: SH_W] != SH_OUTER);

    // R5: accepted write leaves a usable inner attribute
    a_r5_inner_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !lock_i) |=> (q_o[IN_LSB +: IN_W] > IC_NOCACHE));

    // R6: outer attribute restricted to two codes
    a_r6_outer_legal: assert property (@(posedge clk) disable iff (!rst_n)
        q_o[OUT_LSB +: OUT_W] <= OC_NOCACHE);

    // R7/R8: reserved bits stay clear
    a_r7_r8_res0_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (q_o & RES0) == '0);

endmodule

// File: rtl/lpi_table_regs.sv
module lpi_table_regs
    import lpi_tbl_pkg::*;
#(
    parameter int ADDR_W = 4
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              its_present,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_wide,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [63:0]       req_wdata,
    output logic              rsp_valid,
    output logic [63:0]       rsp_rdata,
    output logic              lpi_en,
    output logic              flush_pulse,
    output logic              enable_pulse
);

    localparam int SLOT_W = ADDR_W - 1;
    localparam logic [NUM_TBL-1:0][WORD_W-1:0] TBL_RES0 = {PEND_RES0, PROP_RES0};

    logic [SLOT_W-1:0] slot;
    logic              hi;
    logic              do_wr;
    logic              ctrl_wr;
    word_t             tbl_q [NUM_TBL];
    word_t             sel;
    word_t             rd_val;

    assign slot    = req_addr[ADDR_W-1:1];
    assign hi      = req_addr[0];
    assign do_wr   = req_valid && req_write;
    assign ctrl_wr = do_wr && (slot == SLOT_W'(CTRL_SLOT)) && (req_wide || !hi);

    lpi_ctrl_fsm u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .its_present_i(its_present),
        .wr_i         (ctrl_wr),
        .wr_bit_i     (req_wdata[0]),
        .en_o         (lpi_en),
        .flush_o      (flush_pulse),
        .enable_o     (enable_pulse)
    );

    for (genvar t = 0; t < NUM_TBL; t++) begin : g_tbl
        logic tbl_wr;
        assign tbl_wr = do_wr && (slot == SLOT_W'(TBL_SLOT0 + t));

        lpi_base_reg #(
            .RES0(TBL_RES0[t])
        ) u_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_i   (tbl_wr),
            .wide_i (req_wide),
            .hi_i   (hi),
            .wdata_i(req_wdata),
            .lock_i (lpi_en),
            .q_o    (tbl_q[t])
        );
    end

    always_comb begin
        sel = '0;
        if (slot == SLOT_W'(CTRL_SLOT))
            sel = {{(WORD_W-1){1'b0}}, lpi_en};
        for (int t = 0; t < NUM_TBL; t++) begin
            if (slot == SLOT_W'(TBL_SLOT0 + t))
                sel = tbl_q[t];
        end
        if (req_wide)
            rd_val = sel;
        else if (hi)
            rd_val = {{HALF_W{1'b0}}, sel[WORD_W-1:HALF_W]};
        else
            rd_val = {{HALF_W{1'b0}}, sel[HALF_W-1:0]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid && !req_write;
            rsp_rdata <= (req_valid && !req_write) ? rd_val : '0;
        end
    end

    // R12: reads answer next cycle, writes never answer
    a_r12_read_answers: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);
    a_r12_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> !rsp_valid);
    // R2: a 32-bit read never fills the upper half
    a_r2_narrow_read_zero_top: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !req_wide) |=> (rsp_rdata[63:32] == '0));

endmodule

// File: tb/lpi_table_regs_bench.sv
module lpi_table_regs_bench;

    localparam int ADDR_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              its_present = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic              req_wide = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [63:0]       req_wdata = '0;
    logic              rsp_valid;
    logic [63:0]       rsp_rdata;
    logic              lpi_en;
    logic              flush_pulse;
    logic              enable_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [63:0] m_prop = '0;
    logic [63:0] m_pend = '0;
    logic        m_en = 1'b0;

    always #2.5 clk = ~clk;

    lpi_table_regs #(.ADDR_W(ADDR_W)) u_lpi_table_regs (
        .clk(clk), .rst_n(rst_n), .its_present(its_present),
        .req_valid(req_valid), .req_write(req_write), .req_wide(req_wide),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .lpi_en(lpi_en),
        .flush_pulse(flush_pulse), .enable_pulse(enable_pulse)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] clean(input logic [63:0] v, input bit pend);
        logic [63:0] r = v;
        if (v[11:10] == 2'b10) r[11:10] = 2'b01;
        if (v[9:8] == 2'b00) r[9:7] = 3'b111;
        if (v[58:57] != 2'b00) r[58:56] = 3'b001;
        if (pend) begin
            r[63] = 0; r[61:59] = 0; r[55:52] = 0; r[15:12] = 0; r[6:0] = 0;
        end else begin
            r[63:59] = 0; r[55:52] = 0; r[6:5] = 0;
        end
        return r;
    endfunction

    function automatic logic [63:0] put(input logic [63:0] cur, input logic [63:0] wd,
                                        input bit wide, input bit hi);
        if (wide) return wd;
        if (hi)   return {wd[31:0], cur[31:0]};
        return {cur[63:32], wd[31:0]};
    endfunction

    // one access; checks response and pulses at the following falling edge
    task automatic access(input bit wr, input bit wide, input logic [ADDR_W-1:0] a,
                          input logic [63:0] wd, input string req);
        logic [63:0] v, exp_rd;
        bit ep, fp, nb;
        ep = 0; fp = 0;
        case (a[ADDR_W-1:1])
            0: v = {63'b0, m_en};
            2: v = m_prop;
            3: v = m_pend;
            default: v = '0;
        endcase
        exp_rd = wide ? v : (a[0] ? {32'b0, v[63:32]} : {32'b0, v[31:0]});
        req_valid = 1; req_write = wr; req_wide = wide; req_addr = a; req_wdata = wd;
        @(posedge clk);
        if (wr) begin
            case (a[ADDR_W-1:1])
                0: if (its_present && (wide || !a[0])) begin
                       nb = wd[0];
                       ep = !m_en && nb; fp = m_en && !nb; m_en = nb;
                   end
                2: if (!m_en) m_prop = clean(put(m_prop, wd, wide, a[0]), 0);
                3: if (!m_en) m_pend = clean(put(m_pend, wd, wide, a[0]), 1);
                default: ;
            endcase
        end
        @(negedge clk);
        req_valid = 0; req_write = 0;
        chk({req, " R12 rsp_valid"}, {63'b0, rsp_valid}, {63'b0, !wr});
        if (!wr) chk({req, " rdata"}, rsp_rdata, exp_rd);
        chk({req, " R11 enable_pulse"}, {63'b0, enable_pulse}, {63'b0, ep});
        chk({req, " R11 flush_pulse"}, {63'b0, flush_pulse}, {63'b0, fp});
        chk({req, " lpi_en"}, {63'b0, lpi_en}, {63'b0, m_en});
    endtask

    initial begin
        void'($urandom(32'hC0FFEE));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 lpi_en", {63'b0, lpi_en}, 0);
        chk("R1 pulses", {62'b0, flush_pulse, enable_pulse}, 0);
        chk("R1 rsp_valid", {63'b0, rsp_valid}, 0);
        access(0, 1, 4, 0, "R1 prop reset");
        access(0, 1, 6, 0, "R1 pend reset");

        // R2 half writes
        access(1, 0, 4, 64'h0000_0000_1234_5F80, "R2 prop low");
        access(1, 0, 5, 64'h0000_0000_0100_00AB, "R2 prop high");
        access(0, 0, 5, 0, "R2 read high half");
        access(0, 0, 4, 0, "R2 read low half");
        // R3 wide write with odd address
        access(1, 1, 7, 64'hFFFF_FFFF_FFFF_FFFF, "R3 R8 pend wide all ones");
        access(0, 1, 6, 0, "R3 R8 pend readback");
        access(1, 1, 4, 64'hFFFF_FFFF_FFFF_FFFF, "R7 prop all ones");
        access(0, 1, 5, 0, "R7 prop readback");
        // R4/R5/R6 specific codes
        access(1, 1, 4, 64'h0700_0000_0000_0800, "R4 R6 share2 outer7");
        access(0, 1, 4, 0, "R4 R5 R6 readback");
        access(1, 1, 6, 64'h0100_0000_0000_0C80, "R4 R5 share3 inner1");
        access(0, 1, 6, 0, "R4 R5 R6 readback2");
        // R12 unmapped
        access(1, 1, 2, 64'hFFFF, "R12 unmapped write");
        access(0, 1, 2, 0, "R12 unmapped read");
        // R10 no ITS
        its_present = 0;
        access(1, 0, 0, 1, "R10 write without ITS");
        its_present = 1;
        access(1, 0, 1, 1, "R10 write word1");
        access(0, 0, 1, 0, "R10 read word1");
        // R11 enable then immediate base write must be locked (R9)
        access(1, 0, 0, 1, "R11 enable");
        access(1, 1, 4, 64'h0000_0000_0000_0F80, "R9 locked prop write");
        access(1, 0, 7, 64'hFFFF_FFFF, "R9 locked pend write");
        access(0, 1, 4, 0, "R9 prop unchanged");
        access(0, 1, 6, 0, "R9 pend unchanged");
        access(1, 0, 0, 1, "R11 same value no pulse");
        its_present = 0;
        access(1, 0, 0, 0, "R10 disable blocked");
        its_present = 1;
        access(1, 0, 0, 0, "R11 disable flush");
        access(1, 1, 4, 64'h0000_0000_0000_0400, "R9 write right after unlock");
        access(0, 1, 4, 0, "R9 unlock readback");
        access(0, 0, 0, 0, "R10 ctrl read");

        // random phase
        for (int i = 0; i < 1500; i++) begin
            logic [ADDR_W-1:0] a;
            logic [63:0] wd;
            int k;
            k = $urandom_range(0, 9);
            case (k)
                0, 1: a = ADDR_W'($urandom_range(0, 1));
                9:    a = ADDR_W'($urandom_range(2, 3) | ($urandom_range(0, 1) << 3));
                default: a = ADDR_W'($urandom_range(4, 7));
            endcase
            wd = {$urandom, $urandom};
            its_present = ($urandom_range(0, 4) != 0);
            access($urandom_range(0, 1), $urandom_range(0, 1), a, wd, "R2 R3 R9 random");
        end
        its_present = 1;

        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule